// File: doc/BRIEF.md
# Bus Event Interrupt Aggregator

This block collects the interrupt sources of an external memory bus controller and merges them into a single interrupt request line. Two sources are one-cycle pulses from a NAND transfer engine: a FIFO threshold event and a transfer terminal-count event. The others are a parameterised set of asynchronous wait pins. Each wait pin passes through a two-flop synchroniser and then an edge detector. A per-pin selection bit chooses whether the rising or the falling edge counts as an event.

Every source owns a sticky status bit and an enable bit. Software reaches them through a small register port. It clears status by writing ones, and an event arriving in the same cycle as its clear wins. The interrupt line is high whenever any enabled status bit is set. The synchronised wait pin levels can also be read back as general-purpose inputs.

Top module: `bei_irq_aggregator`

## Requirements
- R1: After reset, the status, enable and edge-select registers read zero, and `irq` is low.
- R2: A one-cycle pulse on `nand_fifo_evt` sets status bit 0 on the next clock edge. Status bit 0 never sets without that pulse.
- R3: A one-cycle pulse on `nand_tc_evt` sets status bit 1 on the next clock edge.
- R4: Status bit 2+k records an edge on wait pin k. If edge-select bit k is 1, only a rising edge counts; if it is 0, only a falling edge counts. The opposite edge leaves the status bit unchanged.
- R5: `gpi[k]` and bit k of the level register (address 3) show wait pin k through a two-flop synchroniser. A pin value set before clock edge N appears after edge N+1, and not after edge N alone.
- R6: Status bits are sticky. Writing to address 0 clears every status bit whose data bit is 1. Bits written with 0 are unchanged.
- R7: When an event and a clear of the same status bit occur in the same cycle, the bit stays set. Other bits in that write still clear.
- R8: `irq` is high exactly when some status bit and its enable bit are both 1. A disabled source still sets its status bit but does not raise `irq`. Writing all-zero enables drops `irq` on the next cycle.
- R9: The register map is as follows:
  - Address 0 is status, read and write-1-to-clear.
  - Address 1 is enable, read/write, with bit i matching status bit i.
  - Address 2 is edge select, read/write, with one bit per wait pin.
  - Address 3 is the pin level, read only; writes to it are ignored.
  - Bits above each register's width read 0, and `reg_rdata` is combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nand_fifo_evt | input | 1 | FIFO threshold pulse from the NAND engine |
| nand_tc_evt | input | 1 | Terminal-count pulse from the NAND engine |
| wait_pin | input | NUM_WAIT | Asynchronous wait pins |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Merged interrupt request |
| gpi | output | NUM_WAIT | Synchronised wait pin levels |

## Verification
On every cycle, the assertions check four things. The NAND pulses must set their status bits on the next edge. A set bit must hold unless it is written with a one, and an event must win over a same-cycle clear. Clearing the enables must drop the interrupt, and the reported pin levels must follow the pins two cycles later. Some behaviour is shown only by the bench's directed scenarios: edge polarity selection per pin, the exact synchroniser latency, the isolation of disabled sources from `irq`, and the register map read-back.

// File: rtl/bei_pkg.sv
package bei_pkg;

    typedef enum logic [1:0] {
        ADDR_STATUS   = 2'd0,
        ADDR_ENABLE   = 2'd1,
        ADDR_EDGE_SEL = 2'd2,
        ADDR_LEVEL    = 2'd3
    } bei_addr_e;

    localparam int SRC_FIFO      = 0;
    localparam int SRC_TC        = 1;
    localparam int SRC_WAIT_BASE = 2;

    typedef struct packed {
        logic      wr;
        bei_addr_e addr;
    } bei_cmd_t;

    function automatic logic hits(bei_cmd_t cmd, bei_addr_e target);
        return cmd.wr && (cmd.addr == target);
    endfunction

endpackage

// File: rtl/bei_wait_edge.sv
module bei_wait_edge #(
    parameter int NUM_WAIT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_WAIT-1:0] pin_async,
    input  logic [NUM_WAIT-1:0] rise_sel,
    output logic [NUM_WAIT-1:0] level,
    output logic [NUM_WAIT-1:0] edge_evt
);
    for (genvar k = 0; k < NUM_WAIT; k++) begin : g_pin
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_async[k];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level[k]    = sync_q;
        assign edge_evt[k] = rise_sel[k] ? (sync_q & ~prev_q) : (~sync_q & prev_q);
    end
endmodule

// File: rtl/bei_sticky_bank.sv
module bei_sticky_bank #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] status
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)         bit_q <= 1'b0;
            else if (evt[i]) bit_q <= 1'b1;
            else if (clr[i]) bit_q <= 1'b0;
        end
        assign status[i] = bit_q;
    end
endmodule

// File: rtl/bei_cfg_regs.sv
module bei_cfg_regs
    import bei_pkg::*;
#(
    parameter int NUM_WAIT = 2,
    parameter int DATA_W   = 32,
    localparam int NUM_SRC = SRC_WAIT_BASE + NUM_WAIT
) (
    input  logic                clk,
    input  logic                rst,
    input  bei_cmd_t            cmd,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_SRC-1:0]  status,
    input  logic [NUM_WAIT-1:0] level,
    output logic [NUM_SRC-1:0]  enable,
    output logic [NUM_WAIT-1:0] rise_sel,
    output logic [NUM_SRC-1:0]  clr,
    output logic [DATA_W-1:0]   rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            enable   <= '0;
            rise_sel <= '0;
        end else begin
            if (hits(cmd, ADDR_ENABLE))   enable   <= wdata[NUM_SRC-1:0];
            if (hits(cmd, ADDR_EDGE_SEL)) rise_sel <= wdata[NUM_WAIT-1:0];
        end
    end

    assign clr = hits(cmd, ADDR_STATUS) ? wdata[NUM_SRC-1:0] : '0;

    always_comb begin
        rdata = '0;
        unique case (cmd.addr)
            ADDR_STATUS:   rdata[NUM_SRC-1:0]  = status;
            ADDR_ENABLE:   rdata[NUM_SRC-1:0]  = enable;
            ADDR_EDGE_SEL: rdata[NUM_WAIT-1:0] = rise_sel;
            ADDR_LEVEL:    rdata[NUM_WAIT-1:0] = level;
            default:       rdata = '0;
        endcase
    end
endmodule

// File: rtl/bei_irq_aggregator.sv
module bei_irq_aggregator
    import bei_pkg::*;
#(
    parameter int NUM_WAIT = 2,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                nand_fifo_evt,
    input  logic                nand_tc_evt,
    input  logic [NUM_WAIT-1:0] wait_pin,
    input  logic                reg_wr_en,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq,
    output logic [NUM_WAIT-1:0] gpi
);
    localparam int NUM_SRC = SRC_WAIT_BASE + NUM_WAIT;

    bei_cmd_t            cmd;
    logic [NUM_WAIT-1:0] rise_sel;
    logic [NUM_WAIT-1:0] wait_edge;
    logic [NUM_SRC-1:0]  src_evt;
    logic [NUM_SRC-1:0]  src_clr;
    logic [NUM_SRC-1:0]  status_q;
    logic [NUM_SRC-1:0]  enable_q;

    assign cmd.wr   = reg_wr_en;
    assign cmd.addr = bei_addr_e'(reg_addr);

    bei_wait_edge #(.NUM_WAIT(NUM_WAIT)) wait_i (
        .clk      (clk),
        .rst      (rst),
        .pin_async(wait_pin),
        .rise_sel (rise_sel),
        .level    (gpi),
        .edge_evt (wait_edge)
    );

    assign src_evt = {wait_edge, nand_tc_evt, nand_fifo_evt};

    bei_sticky_bank #(.NUM_SRC(NUM_SRC)) bank_i (
        .clk   (clk),
        .rst   (rst),
        .evt   (src_evt),
        .clr   (src_clr),
        .status(status_q)
    );

    bei_cfg_regs #(.NUM_WAIT(NUM_WAIT), .DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wdata   (reg_wdata),
        .status  (status_q),
        .level   (gpi),
        .enable  (enable_q),
        .rise_sel(rise_sel),
        .clr     (src_clr),
        .rdata   (reg_rdata)
    );

    assign irq = |(status_q & enable_q);
endmodule

// File: rtl/bei_irq_aggregator_chk.sv
module bei_irq_aggregator_chk #(
    parameter int NUM_WAIT = 2,
    parameter int DATA_W   = 32,
    localparam int NUM_SRC = 2 + NUM_WAIT
) (
    input logic                clk,
    input logic                rst,
    input logic                nand_fifo_evt,
    input logic                nand_tc_evt,
    input logic [NUM_WAIT-1:0] wait_pin,
    input logic                reg_wr_en,
    input logic [1:0]          reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                irq,
    input logic [NUM_WAIT-1:0] gpi,
    input logic [NUM_SRC-1:0]  status_q
);
    logic [1:0] since_rst;
    logic       clr0;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    assign clr0 = reg_wr_en && (reg_addr == 2'd0) && reg_wdata[0];

    AST_FIFO_SETS: assert property (@(posedge clk) disable iff (rst)
        nand_fifo_evt |=> status_q[0]);                                   // R2
    AST_FIFO_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!status_q[0] && !nand_fifo_evt) |=> !status_q[0]);               // R2
    AST_TC_SETS: assert property (@(posedge clk) disable iff (rst)
        nand_tc_evt |=> status_q[1]);                                     // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status_q[0] && !clr0) |=> status_q[0]);                          // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (nand_fifo_evt && clr0) |=> status_q[0]);                         // R7
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 2'd1 && reg_wdata == '0) |=> !irq);    // R8
    AST_GPI_SYNC: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2) |-> (gpi == $past(wait_pin, 2)));                // R5
endmodule

bind bei_irq_aggregator bei_irq_aggregator_chk #(
    .NUM_WAIT(NUM_WAIT), .DATA_W(DATA_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .nand_fifo_evt(nand_fifo_evt),
    .nand_tc_evt  (nand_tc_evt),
    .wait_pin     (wait_pin),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .irq          (irq),
    .gpi          (gpi),
    .status_q     (status_q)
);

// File: tb/bei_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module bei_irq_aggregator_tb_top;
    localparam int NW = 2;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fifo_evt = 1'b0, tc_evt = 1'b0;
    logic [NW-1:0] pins = '0;
    logic          wr = 1'b0;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;
    logic [NW-1:0] gpi;

    int n_checks = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    bei_irq_aggregator #(.NUM_WAIT(NW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .nand_fifo_evt(fifo_evt), .nand_tc_evt(tc_evt),
        .wait_pin(pins), .reg_wr_en(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq(irq), .gpi(gpi)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input bit tc);
        @(negedge clk);
        if (tc) tc_evt = 1'b1; else fifo_evt = 1'b1;
        @(negedge clk);
        tc_evt = 1'b0; fifo_evt = 1'b0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        reg_read(2'd0, v); check("R1 status", v, 0);
        reg_read(2'd1, v); check("R1 enable", v, 0);
        reg_read(2'd2, v); check("R1 edge_sel", v, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_nand;
        logic [DW-1:0] v;
        pulse(0);
        reg_read(2'd0, v); check("R2 fifo sets bit0", v, 32'h1);
        reg_write(2'd0, 32'h0);
        reg_read(2'd0, v); check("R6 write 0 keeps", v, 32'h1);
        pulse(1);
        reg_read(2'd0, v); check("R3 tc sets bit1", v, 32'h3);
        reg_write(2'd0, 32'h1);
        reg_read(2'd0, v); check("R6 w1c bit0 only", v, 32'h2);
        reg_write(2'd0, 32'hF);
        reg_read(2'd0, v); check("R6 clear all", v, 32'h0);
    endtask

    task automatic t_wait_edges;
        logic [DW-1:0] v;
        reg_write(2'd2, 32'h1);
        @(negedge clk); pins[0] = 1'b1;
        cycles(3);
        reg_read(2'd0, v); check("R4 pin0 rising", v, 32'h4);
        @(negedge clk); pins[1] = 1'b1;
        cycles(4);
        reg_read(2'd0, v); check("R4 pin1 rising ignored", v, 32'h4);
        @(negedge clk); pins[1] = 1'b0;
        cycles(4);
        reg_read(2'd0, v); check("R4 pin1 falling", v, 32'hC);
        reg_write(2'd0, 32'hC);
        @(negedge clk); pins[0] = 1'b0;
        cycles(4);
        reg_read(2'd0, v); check("R4 pin0 falling ignored", v, 32'h0);
    endtask

    task automatic t_levels;
        logic [DW-1:0] v;
        @(negedge clk); pins = 2'b10;
        @(negedge clk); check("R5 not after one edge", {30'd0, gpi}, 32'h0);
        @(negedge clk); check("R5 after two edges", {30'd0, gpi}, 32'h2);
        reg_write(2'd3, 32'hFF);
        reg_read(2'd3, v); check("R9 level ro", v, 32'h2);
        @(negedge clk); pins = 2'b00;
        cycles(4);
        reg_write(2'd0, 32'hF);
        reg_read(2'd3, v); check("R5 level low", v, 32'h0);
    endtask

    task automatic t_irq;
        logic [DW-1:0] v;
        reg_write(2'd1, 32'h1);
        pulse(1);
        reg_read(2'd0, v); check("R8 disabled sets status", v, 32'h2);
        check("R8 disabled no irq", {31'd0, irq}, 0);
        pulse(0);
        check("R8 enabled irq", {31'd0, irq}, 1);
        reg_write(2'd1, 32'h0);
        check("R8 irq drops", {31'd0, irq}, 0);
        reg_write(2'd1, 32'h2);
        check("R8 enable tc irq", {31'd0, irq}, 1);
        reg_write(2'd0, 32'hF);
        check("R8 clear drops irq", {31'd0, irq}, 0);
        reg_write(2'd1, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [DW-1:0] v;
        pulse(1);
        @(negedge clk);
        fifo_evt = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 32'h3;
        @(negedge clk);
        fifo_evt = 1'b0; wr = 1'b0; wdata = '0;
        reg_read(2'd0, v); check("R7 set wins over clear", v, 32'h1);
        reg_write(2'd0, 32'hF);
    endtask

    task automatic t_regmap;
        logic [DW-1:0] v;
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd1, v); check("R9 enable width", v, 32'hF);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_read(2'd2, v); check("R9 edge_sel width", v, 32'h3);
        reg_write(2'd1, 32'h0);
        reg_write(2'd2, 32'h0);
        reg_read(2'd1, v); check("R9 enable cleared", v, 32'h0);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        t_reset();
        t_nand();
        t_wait_edges();
        t_levels();
        t_irq();
        t_set_wins();
        t_regmap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule